// File: doc/BRIEF.md
# Pulse-Width Bit Encoder Serializer

This block converts a frame of data bits into a one-wire waveform in which every bit is a fixed-length symbol of slot clocks. Each symbol starts high, and the width of the high part tells the receiver whether the bit is a 0 or a 1. With the reset timing, a 0 bit is 17 high slots then 43 low slots, and a 1 bit is 43 high slots then 17 low slots. That gives a 60-slot symbol, or about 21 ns per slot on a 48 MHz slot clock. The symbols of a frame follow each other with no gap. The output rests low between frames.

Bytes arrive on a valid/ready stream and are consumed most significant bit first. A single strobe starts a frame. The frame length in bits comes from a register, 360 by default, so a frame may end part way through its last byte. A one-byte holding buffer lets the source deliver the next byte while the current one is being sent. If the source misses that window, the frame stops at the byte boundary and a sticky underrun flag is raised. The four slot counts and the frame length can be written through a small configuration port whenever the serializer is idle.

Top module: `pwc_serializer`

## Requirements
- R1: After reset, sout, busy, din_ready and underrun are low. The reset timing is 17 high / 43 low slots for a 0 bit and 43 high / 17 low for a 1 bit, and the frame length is 360 bits.
- R2: A 0 bit produces zero-high-count slots at level 1, followed by zero-low-count slots at level 0.
- R3: A 1 bit produces one-high-count slots at level 1, followed by one-low-count slots at level 0.
- R4: Bits are taken from each byte starting at bit 7. The first symbol begins in the cycle after the first byte is accepted, and every later symbol begins in the cycle after the previous one ends.
- R5: busy goes high in the cycle after an accepted start and stays high through the final slot of the last symbol. It goes low in the next cycle. sout is low whenever busy is low.
- R6: A frame carries exactly frame-length bits, so a last byte may be only partly used. A frame that ends on a byte boundary does not raise underrun.
- R7: A write on the configuration port selects a register by cfg_addr: 0 is the 0-bit high count, 1 the 0-bit low count, 2 the 1-bit high count, 3 the 1-bit low count and 4 the frame length. The slot counts take cfg_wdata[7:0], and the frame length takes all 16 bits. Writes made while busy is high are ignored.
- R8: The current byte's last symbol may end while more bits remain and no next byte is buffered. In that case the frame ends after that symbol's final slot and underrun goes high in the same cycle that busy falls. underrun stays high until the next accepted start clears it.
- R9: din_ready is high while busy is high and no byte has yet been accepted for the frame. After the first byte it is high only while the one-byte buffer is empty. It is low while idle.
- R10: A start pulse is ignored while busy is high, and it is also ignored when the frame length is 0.
- R11: A slot count of 0 produces no slots at that level. A symbol with both counts 0 is a single low slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 16 | Configuration write data |
| start | input | 1 | Frame start strobe |
| din_valid | input | 1 | Input byte valid |
| din_data | input | 8 | Input byte, sent bit 7 first |
| din_ready | output | 1 | Block can take a byte this cycle |
| busy | output | 1 | Frame in progress |
| underrun | output | 1 | Sticky: the data source fell behind during the last frame |
| sout | output | 1 | Pulse-width coded serial output |

## Verification
busy and din_ready change one cycle after the start edge. The first slot of the first symbol appears one cycle after the edge that accepts the first byte. busy and underrun settle one cycle after the edge that ends the final slot. The bench drives and samples only at falling edges, advancing one clock at a time. Its expected slot counter starts one tick after it sees the accepting handshake, so every symbol is compared slot by slot in the exact cycles it should occupy. End-of-frame flags are read on the tick after the last expected slot.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PRIME = 2'd1,
    ST_SEND  = 2'd2
  } pwc_state_e;

  localparam logic [2:0] CFG_ZERO_HI = 3'd0;
  localparam logic [2:0] CFG_ZERO_LO = 3'd1;
  localparam logic [2:0] CFG_ONE_HI  = 3'd2;
  localparam logic [2:0] CFG_ONE_LO  = 3'd3;
  localparam logic [2:0] CFG_FRAME   = 3'd4;

  // Output level of a slot: high while the slot index is inside the high part.
  function automatic logic slot_is_high(input int unsigned slot, input int unsigned hi_len);
    return slot < hi_len;
  endfunction

  // Last slot of a symbol; an empty symbol still occupies one slot.
  function automatic logic slot_is_final(input int unsigned slot, input int unsigned hi_len,
                                         input int unsigned lo_len);
    return (slot + 1) >= (hi_len + lo_len);
  endfunction

endpackage

// File: rtl/pwc_cfg_regs.sv
module pwc_cfg_regs #(
  parameter int SLOT_W  = 8,
  parameter int FRAME_W = 16,
  parameter int unsigned DEF_ZERO_HI = 17,
  parameter int unsigned DEF_ZERO_LO = 43,
  parameter int unsigned DEF_ONE_HI  = 43,
  parameter int unsigned DEF_ONE_LO  = 17,
  parameter int unsigned DEF_FRAME   = 360
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lock,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_addr,
  input  logic [FRAME_W-1:0] cfg_wdata,
  output logic [SLOT_W-1:0]  zero_hi,
  output logic [SLOT_W-1:0]  zero_lo,
  output logic [SLOT_W-1:0]  one_hi,
  output logic [SLOT_W-1:0]  one_lo,
  output logic [FRAME_W-1:0] frame_bits
);
  import pwc_pkg::*;

  localparam int NTIM = 4;
  localparam logic [SLOT_W-1:0] DEF_TIM [NTIM] = '{
    SLOT_W'(DEF_ZERO_HI), SLOT_W'(DEF_ZERO_LO), SLOT_W'(DEF_ONE_HI), SLOT_W'(DEF_ONE_LO)
  };

  logic [SLOT_W-1:0]  tim_q [NTIM];
  logic [FRAME_W-1:0] frame_q;
  logic               wr_ok;

  assign wr_ok = cfg_we && !lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NTIM; i++) tim_q[i] <= DEF_TIM[i];
      frame_q <= FRAME_W'(DEF_FRAME);
    end else if (wr_ok) begin
      for (int i = 0; i < NTIM; i++)
        if (cfg_addr == 3'(i)) tim_q[i] <= cfg_wdata[SLOT_W-1:0];
      if (cfg_addr == CFG_FRAME) frame_q <= cfg_wdata;
    end
  end

  assign zero_hi    = tim_q[0];
  assign zero_lo    = tim_q[1];
  assign one_hi     = tim_q[2];
  assign one_lo     = tim_q[3];
  assign frame_bits = frame_q;

  // R7
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable({tim_q[0], tim_q[1], tim_q[2], tim_q[3], frame_q}));

endmodule

// File: rtl/pwc_slot_timer.sv
module pwc_slot_timer #(
  parameter int SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              bit_val,
  input  logic [SLOT_W-1:0] zero_hi,
  input  logic [SLOT_W-1:0] zero_lo,
  input  logic [SLOT_W-1:0] one_hi,
  input  logic [SLOT_W-1:0] one_lo,
  output logic              sym_end,
  output logic              level
);
  import pwc_pkg::*;

  localparam int SYM_W = SLOT_W + 1;

  logic [SYM_W-1:0]  slot_q;
  logic [SLOT_W-1:0] hi_sel;
  logic [SLOT_W-1:0] lo_sel;

  assign hi_sel  = bit_val ? one_hi : zero_hi;
  assign lo_sel  = bit_val ? one_lo : zero_lo;
  assign level   = run && slot_is_high(32'(slot_q), 32'(hi_sel));
  assign sym_end = run && slot_is_final(32'(slot_q), 32'(hi_sel), 32'(lo_sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                slot_q <= '0;
    else if (!run || sym_end)  slot_q <= '0;
    else                       slot_q <= slot_q + 1'b1;
  end

  // R2 R3: once a symbol has gone low it stays low until the symbol ends
  low_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !sym_end && !level) |=> !level);

endmodule

// File: rtl/pwc_bit_feed.sv
module pwc_bit_feed #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              priming,
  input  logic              sending,
  input  logic              sym_end,
  input  logic              din_valid,
  input  logic [BYTE_W-1:0] din_data,
  output logic              din_ready,
  output logic              cur_bit,
  output logic              byte_done,
  output logic              nxt_full
);
  localparam int IDX_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] shreg_q;
  logic [BYTE_W-1:0] nxt_q;
  logic              nxt_full_q;
  logic [IDX_W-1:0]  idx_q;
  logic              take;

  assign din_ready = priming || (sending && !nxt_full_q);
  assign take      = din_valid && din_ready;
  assign cur_bit   = shreg_q[BYTE_W-1];
  assign byte_done = (idx_q == '0);
  assign nxt_full  = nxt_full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q    <= '0;
      nxt_q      <= '0;
      nxt_full_q <= 1'b0;
      idx_q      <= '0;
    end else if (frame_start) begin
      nxt_full_q <= 1'b0;
    end else begin
      if (priming && take) begin
        shreg_q <= din_data;
        idx_q   <= IDX_TOP;
      end else if (sending && sym_end) begin
        if (byte_done) begin
          if (nxt_full_q) begin
            shreg_q    <= nxt_q;
            nxt_full_q <= 1'b0;
            idx_q      <= IDX_TOP;
          end
        end else begin
          shreg_q <= shreg_q << 1;
          idx_q   <= idx_q - 1'b1;
        end
      end
      if (sending && take) begin
        nxt_q      <= din_data;
        nxt_full_q <= 1'b1;
      end
    end
  end

  // R9: a buffered byte is held unchanged until it is moved into the shifter
  buf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nxt_full_q && !frame_start && !(sending && sym_end && byte_done))
      |=> (nxt_full_q && $stable(nxt_q)));

endmodule

// File: rtl/pwc_serializer.sv
module pwc_serializer #(
  parameter int SLOT_W  = 8,
  parameter int FRAME_W = 16,
  parameter int BYTE_W  = 8,
  parameter int unsigned DEF_ZERO_HI = 17,
  parameter int unsigned DEF_ZERO_LO = 43,
  parameter int unsigned DEF_ONE_HI  = 43,
  parameter int unsigned DEF_ONE_LO  = 17,
  parameter int unsigned DEF_FRAME   = 360
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_addr,
  input  logic [FRAME_W-1:0] cfg_wdata,
  input  logic               start,
  input  logic               din_valid,
  input  logic [BYTE_W-1:0]  din_data,
  output logic               din_ready,
  output logic               busy,
  output logic               underrun,
  output logic               sout
);
  import pwc_pkg::*;

  pwc_state_e         state_q;
  logic [FRAME_W-1:0] bits_left_q;
  logic               underrun_q;

  logic [SLOT_W-1:0]  zero_hi, zero_lo, one_hi, one_lo;
  logic [FRAME_W-1:0] frame_bits;
  logic               priming, sending, frame_start;
  logic               cur_bit, byte_done, nxt_full;
  logic               sym_end, level;

  assign priming     = (state_q == ST_PRIME);
  assign sending     = (state_q == ST_SEND);
  assign busy        = (state_q != ST_IDLE);
  assign frame_start = (state_q == ST_IDLE) && start && (frame_bits != '0);
  assign underrun    = underrun_q;
  assign sout        = level;

  pwc_cfg_regs #(
    .SLOT_W(SLOT_W), .FRAME_W(FRAME_W),
    .DEF_ZERO_HI(DEF_ZERO_HI), .DEF_ZERO_LO(DEF_ZERO_LO),
    .DEF_ONE_HI(DEF_ONE_HI), .DEF_ONE_LO(DEF_ONE_LO), .DEF_FRAME(DEF_FRAME)
  ) cfg_i (
    .clk(clk), .rst_n(rst_n), .lock(busy),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .zero_hi(zero_hi), .zero_lo(zero_lo), .one_hi(one_hi), .one_lo(one_lo),
    .frame_bits(frame_bits)
  );

  pwc_bit_feed #(.BYTE_W(BYTE_W)) feed_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .priming(priming), .sending(sending), .sym_end(sym_end),
    .din_valid(din_valid), .din_data(din_data), .din_ready(din_ready),
    .cur_bit(cur_bit), .byte_done(byte_done), .nxt_full(nxt_full)
  );

  pwc_slot_timer #(.SLOT_W(SLOT_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .run(sending), .bit_val(cur_bit),
    .zero_hi(zero_hi), .zero_lo(zero_lo), .one_hi(one_hi), .one_lo(one_lo),
    .sym_end(sym_end), .level(level)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      bits_left_q <= '0;
      underrun_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (frame_start) begin
          state_q     <= ST_PRIME;
          bits_left_q <= frame_bits;
          underrun_q  <= 1'b0;
        end
        ST_PRIME: if (din_valid) state_q <= ST_SEND;
        ST_SEND: if (sym_end) begin
          bits_left_q <= bits_left_q - 1'b1;
          if (bits_left_q == FRAME_W'(1)) begin
            state_q <= ST_IDLE;
          end else if (byte_done && !nxt_full) begin
            underrun_q <= 1'b1;
            state_q    <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R5
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sout);

  // R8
  underrun_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun_q) |-> $fell(busy));

  // R6: a frame can only finish at a symbol boundary
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !sym_end) |=> busy);

  // R10
  restart_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (bits_left_q <= $past(bits_left_q)));

endmodule

// File: tb/pwc_serializer_tb_top.sv
module pwc_serializer_tb_top;

  localparam int NV = 5;
  // columns: defaults-only, slot counts, frame bits, bytes supplied,
  // expected symbols, expected underrun, restart-attempt symbol, seed
  localparam int V_DEF  [NV] = '{1, 0, 0, 0, 0};
  localparam int V_ZH   [NV] = '{17, 2, 1, 3, 2};
  localparam int V_ZL   [NV] = '{43, 3, 1, 0, 2};
  localparam int V_OH   [NV] = '{43, 4, 2, 0, 3};
  localparam int V_OL   [NV] = '{17, 1, 0, 0, 1};
  localparam int V_BITS [NV] = '{360, 8, 13, 16, 24};
  localparam int V_NB   [NV] = '{45, 1, 2, 2, 1};
  localparam int V_SYMS [NV] = '{360, 8, 13, 16, 8};
  localparam int V_UND  [NV] = '{0, 0, 0, 0, 1};
  localparam int V_MID  [NV] = '{-1, -1, 5, -1, -1};
  localparam int V_SEED [NV] = '{165, 60, 240, 90, 129};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        start = 1'b0;
  logic        din_valid = 1'b0;
  logic [7:0]  din_data = '0;
  logic        din_ready, busy, underrun, sout;

  int checks = 0;
  int fails  = 0;
  int feed_idx = 0, feed_n = 0, feed_wait = 0, feed_seed = 0;
  bit prev_take = 1'b0;

  pwc_serializer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .start(start), .din_valid(din_valid),
    .din_data(din_data), .din_ready(din_ready), .busy(busy),
    .underrun(underrun), .sout(sout)
  );

  initial forever #10 clk = ~clk;

  function automatic logic [7:0] byte_of(input int seed, input int i);
    int t;
    t = seed * 7 + i * 53 + (i >> 2);
    return t[7:0];
  endfunction

  task automatic feed_step();
    if (prev_take) feed_idx++;
    if (feed_wait > 0) feed_wait--;
    din_valid = (feed_wait == 0) && (feed_idx < feed_n);
    din_data  = byte_of(feed_seed, feed_idx);
    prev_take = din_valid && din_ready;
  endtask

  task automatic tick();
    @(negedge clk);
    feed_step();
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input int addr, input int data);
    cfg_we = 1'b1; cfg_addr = 3'(addr); cfg_wdata = 16'(data);
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic run_frame(input int v);
    int n, bad, bad_slot, hi, lo, len;
    logic b;
    string req;
    if (V_DEF[v] == 0) begin
      cfg_write(0, V_ZH[v]); cfg_write(1, V_ZL[v]);
      cfg_write(2, V_OH[v]); cfg_write(3, V_OL[v]);
      cfg_write(4, V_BITS[v]);
    end
    feed_n = V_NB[v]; feed_idx = 0; feed_wait = 3; prev_take = 1'b0;
    feed_seed = V_SEED[v];
    start = 1'b1;
    tick();
    start = 1'b0;
    check(busy == 1'b1, "R5", "busy after start", int'(busy), 1);
    check(din_ready == 1'b1, "R9", "ready while priming", int'(din_ready), 1);
    check(underrun == 1'b0, "R8", "underrun cleared by start", int'(underrun), 0);
    n = 0; bad = 0;
    while (!prev_take && n < 50) begin
      tick();
      if (sout !== 1'b0 || busy !== 1'b1) bad++;
      n++;
    end
    check(bad == 0 && prev_take, "R9", "low output while waiting for first byte", bad, 0);
    for (int j = 0; j < V_SYMS[v]; j++) begin
      b   = byte_of(V_SEED[v], j / 8) [7 - (j % 8)];
      hi  = b ? V_OH[v] : V_ZH[v];
      lo  = b ? V_OL[v] : V_ZL[v];
      len = (hi + lo == 0) ? 1 : hi + lo;
      bad = 0; bad_slot = -1;
      for (int s = 0; s < len; s++) begin
        if (j == V_MID[v] && s == 0) begin
          start = 1'b1; cfg_we = 1'b1; cfg_addr = 3'd0; cfg_wdata = 16'd9;
        end
        tick();
        start = 1'b0; cfg_we = 1'b0;
        if (sout !== (s < hi) || busy !== 1'b1) begin
          if (bad == 0) bad_slot = s;
          bad++;
        end
        if (j == 0 && s == len - 1 && len >= 2 && V_NB[v] > 1)
          check(din_ready == 1'b0, "R9", "ready low with buffer full", int'(din_ready), 0);
      end
      req = {b ? "R3" : "R2", " R4", (V_DEF[v] != 0) ? " R1" : " R7",
             (hi == 0 || lo == 0) ? " R11" : "", (V_MID[v] >= 0) ? " R10" : ""};
      check(bad == 0, req, $sformatf("vector %0d symbol %0d first bad slot", v, j), bad_slot, -1);
    end
    tick();
    check(busy == 1'b0 && sout == 1'b0, "R5 R6", $sformatf("vector %0d end busy", v), int'(busy), 0);
    check(din_ready == 1'b0, "R9", "ready low when idle", int'(din_ready), 0);
    check(underrun == 1'(V_UND[v]), "R8", $sformatf("vector %0d underrun", v), int'(underrun), V_UND[v]);
    feed_n = 0;
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) tick();
    check(sout == 1'b0 && busy == 1'b0, "R1", "outputs in reset", int'(busy), 0);
    rst_n = 1'b1;
    tick();
    check(sout == 1'b0 && busy == 1'b0 && din_ready == 1'b0 && underrun == 1'b0,
          "R1", "idle after reset", int'({sout, busy, din_ready, underrun}), 0);

    for (int v = 0; v < NV; v++) run_frame(v);

    // R10: zero-length frame never starts; R8: flag still held from last frame
    cfg_write(4, 0);
    start = 1'b1;
    tick();
    start = 1'b0;
    check(busy == 1'b0 && din_ready == 1'b0, "R10", "start with zero frame length", int'(busy), 0);
    check(underrun == 1'b1, "R8", "underrun sticky while idle", int'(underrun), 1);
    // R8: a fresh frame clears the flag and runs normally
    run_frame(1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule